// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatcher

This block turns a single software write into one control action aimed at one processor. A write word carries a two-bit command, a target processor number and a six-bit vector. The block can post the vector as an interrupt, put the processor into reset and start it again, halt it so that interrupts no longer wake it, or resume it. Each action appears on a per-processor strobe for exactly one clock cycle.

Writes arrive over a valid/ready channel. `wr_ready` is low while reset is asserted and in the first cycle after reset is released. After that it stays high, because each command is fully handled in the cycle it is accepted. The block never applies back-pressure once it is running. A beat counts only in a cycle where `wr_valid` and `wr_ready` are both high.

A command aimed at a processor number at or above the configured count is dropped without a trace. A reset command that carries any vector other than the power-on code is rejected. A rejected reset sets a sticky error flag, which software clears with a pulse.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset, every strobe output is 0, `post_vec` is 0, `err_flag` is 0 and `wr_ready` is 0. While `rst_n` is low, `wr_ready` is 0. From the second cycle after reset is released, `wr_ready` is 1.
- R2: Write data fields are: command in bits 17:16, target processor in bits 12:8, and vector in bits 5:0. All other bits have no effect on any output.
- R3: Command 0 with an in-range target raises only `post_stb[target]`, with `post_vec` equal to the vector, in the cycle after acceptance. In every cycle without a post strobe, `post_vec` is 0.
- R4: Command 1 whose vector equals `POR_VEC` (default 6'h01) raises both `rst_stb[target]` and `wake_stb[target]` in the cycle after acceptance.
- R5: Command 1 with any other vector raises no strobe and sets `err_flag` in the cycle after acceptance.
- R6: Command 2 raises only `halt_stb[target]` in the cycle after acceptance.
- R7: Command 3 raises only `wake_stb[target]` in the cycle after acceptance.
- R8: A command whose target is at or above `num_cpus` raises no strobe and does not set `err_flag`, even when it is a reset with a bad vector.
- R9: `err_flag` stays set until a cycle with `err_clear` high. If a new rejection and `err_clear` fall in the same cycle, the flag ends up set.
- R10: Every strobe lasts exactly one cycle. A strobe appears only in the cycle after an accepted beat. Back-to-back beats give strobes in back-to-back cycles.
- R11: A cycle with `wr_valid` low produces no strobe, whatever `wr_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| num_cpus | input | 6 | Number of processors that exist; targets at or above this are dropped |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Block can accept a beat |
| wr_data | input | 64 | Command word |
| err_clear | input | 1 | Pulse to clear the sticky error flag |
| post_stb | output | 32 | Per-processor interrupt post strobe |
| post_vec | output | 6 | Vector accompanying the post strobe |
| rst_stb | output | 32 | Per-processor reset strobe |
| halt_stb | output | 32 | Per-processor halt strobe |
| wake_stb | output | 32 | Per-processor resume strobe |
| err_flag | output | 1 | Sticky flag for a rejected reset command |

## Verification
The bench targets the edge of the processor count. A target equal to `num_cpus` must be dropped, while one just below it must act. A comparison with the wrong sense would either strobe a processor that does not exist or silence the last real one.

It also sends a bad-vector reset to an absent processor. A design that checked the vector before the range would wrongly raise the error flag.

Two further cases are checked. The first is a clear and a new rejection landing in the same cycle, where a design that gave priority to the clear would lose the error. The second is data with every unused bit set, which catches a decoder that reads the wrong bit positions.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CPU_ID_W = 5;
  localparam int VEC_W    = 6;
  localparam int DATA_W   = 64;
  localparam int CMD_LSB  = 16;
  localparam int CPU_LSB  = 8;
  localparam int VEC_LSB  = 0;

  typedef enum logic [1:0] {
    CMD_POST  = 2'd0,
    CMD_RESET = 2'd1,
    CMD_HALT  = 2'd2,
    CMD_WAKE  = 2'd3
  } cmd_e;

  typedef struct packed {
    cmd_e                kind;
    logic [CPU_ID_W-1:0] cpu;
    logic [VEC_W-1:0]    vec;
    logic                in_range;
    logic                por_ok;
  } ipi_cmd_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int              MAX_CPUS = 32,
  parameter logic [VEC_W-1:0] POR_VEC = 6'h01,
  localparam int             CNT_W    = $clog2(MAX_CPUS + 1)
) (
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  num_cpus,
  output ipi_cmd_t          cmd
);
  logic [CPU_ID_W:0] cpu_ext;

  always_comb begin
    cmd.kind = cmd_e'(wr_data[CMD_LSB +: 2]);
    cmd.cpu  = wr_data[CPU_LSB +: CPU_ID_W];
    cmd.vec  = wr_data[VEC_LSB +: VEC_W];
    cpu_ext  = {1'b0, cmd.cpu};
    cmd.in_range = ((CPU_ID_W+1)'(cpu_ext) < (CPU_ID_W+1)'(num_cpus))
                && ((CPU_ID_W+1)'(cpu_ext) < (CPU_ID_W+1)'(MAX_CPUS));
    cmd.por_ok = (cmd.vec == POR_VEC);
  end
endmodule

// File: rtl/ipi_strobe_bank.sv
module ipi_strobe_bank
  import ipi_pkg::*;
#(
  parameter int MAX_CPUS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  ipi_cmd_t            cmd,
  output logic [MAX_CPUS-1:0] post_stb,
  output logic [VEC_W-1:0]    post_vec,
  output logic [MAX_CPUS-1:0] rst_stb,
  output logic [MAX_CPUS-1:0] halt_stb,
  output logic [MAX_CPUS-1:0] wake_stb
);
  logic act;
  logic good_rst;
  assign act      = fire && cmd.in_range;
  assign good_rst = (cmd.kind == CMD_RESET) && cmd.por_ok;

  for (genvar i = 0; i < MAX_CPUS; i++) begin : g_cpu
    logic hit;
    assign hit = act && (cmd.cpu == CPU_ID_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        post_stb[i] <= 1'b0;
        rst_stb[i]  <= 1'b0;
        halt_stb[i] <= 1'b0;
        wake_stb[i] <= 1'b0;
      end else begin
        post_stb[i] <= hit && (cmd.kind == CMD_POST);
        rst_stb[i]  <= hit && good_rst;
        halt_stb[i] <= hit && (cmd.kind == CMD_HALT);
        wake_stb[i] <= hit && ((cmd.kind == CMD_WAKE) || good_rst);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_vec <= '0;
    else        post_vec <= (act && cmd.kind == CMD_POST) ? cmd.vec : '0;
  end

  AST_RESET_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_stb) |-> (rst_stb == wake_stb)); // R4
  AST_HALT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_stb) |-> ((wake_stb | post_stb | rst_stb) == '0)); // R6
  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (post_stb == '0) |-> (post_vec == '0)); // R3
endmodule

// File: rtl/ipi_err_flag.sv
module ipi_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set)   flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> flag); // R9
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set && clear) |=> flag); // R9
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int               MAX_CPUS = 32,
  parameter logic [VEC_W-1:0] POR_VEC  = 6'h01,
  localparam int              CNT_W    = $clog2(MAX_CPUS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    num_cpus,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                err_clear,
  output logic [MAX_CPUS-1:0] post_stb,
  output logic [VEC_W-1:0]    post_vec,
  output logic [MAX_CPUS-1:0] rst_stb,
  output logic [MAX_CPUS-1:0] halt_stb,
  output logic [MAX_CPUS-1:0] wake_stb,
  output logic                err_flag
);
  ipi_cmd_t cmd;
  logic     fire;
  logic     bad_rst;
  logic [MAX_CPUS-1:0] any_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  assign fire    = wr_valid && wr_ready;
  assign bad_rst = fire && cmd.in_range && (cmd.kind == CMD_RESET) && !cmd.por_ok;
  assign any_stb = post_stb | rst_stb | halt_stb | wake_stb;

  ipi_decode #(.MAX_CPUS(MAX_CPUS), .POR_VEC(POR_VEC)) u_decode (
    .wr_data (wr_data),
    .num_cpus(num_cpus),
    .cmd     (cmd)
  );

  ipi_strobe_bank #(.MAX_CPUS(MAX_CPUS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .cmd     (cmd),
    .post_stb(post_stb),
    .post_vec(post_vec),
    .rst_stb (rst_stb),
    .halt_stb(halt_stb),
    .wake_stb(wake_stb)
  );

  ipi_err_flag u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (bad_rst),
    .clear(err_clear),
    .flag (err_flag)
  );

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(any_stb)); // R3
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|any_stb) |-> $past(wr_valid && wr_ready)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (any_stb == '0)); // R11
  AST_DROP_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ({1'b0, cmd.cpu} >= (CPU_ID_W+1)'(num_cpus)))
      |=> ((any_stb == '0) && (err_flag == $past(err_flag && !err_clear)))); // R8
  AST_BAD_RESET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rst |=> (err_flag && (any_stb == '0))); // R5
endmodule

// File: tb/ipi_dispatch_bench.sv
module ipi_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  num_cpus = 6'd8;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [63:0] wr_data = '0;
  logic        err_clear = 1'b0;
  logic [31:0] post_stb, rst_stb, halt_stb, wake_stb;
  logic [5:0]  post_vec;
  logic        err_flag;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ipi_dispatch u_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .num_cpus(num_cpus), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .err_clear(err_clear),
    .post_stb(post_stb), .post_vec(post_vec), .rst_stb(rst_stb),
    .halt_stb(halt_stb), .wake_stb(wake_stb), .err_flag(err_flag)
  );

  function automatic logic [63:0] mk(input logic [1:0] t, input logic [4:0] c, input logic [5:0] v);
    return {46'd0, t, 3'd0, c, 2'd0, v};
  endfunction

  localparam logic [63:0] NOISE = 64'hFFFF_FFFF_FFFC_E0C0;

  // {data, ncpu, post, rst, halt, wake, vec, err}
  localparam int NV = 10;
  localparam logic [204:0] TBL [NV] = '{
    {mk(2'd0, 5'd3, 6'h2A),          6'd8,  32'h8,        32'h0,  32'h0,  32'h0,        6'h2A, 1'b0},
    {mk(2'd0, 5'd0, 6'h3F) | NOISE,  6'd8,  32'h1,        32'h0,  32'h0,  32'h0,        6'h3F, 1'b0},
    {mk(2'd1, 5'd5, 6'h01),          6'd8,  32'h0,        32'h20, 32'h0,  32'h20,       6'h00, 1'b0},
    {mk(2'd1, 5'd2, 6'h02),          6'd8,  32'h0,        32'h0,  32'h0,  32'h0,        6'h00, 1'b1},
    {mk(2'd2, 5'd7, 6'h15),          6'd8,  32'h0,        32'h0,  32'h80, 32'h0,        6'h00, 1'b0},
    {mk(2'd3, 5'd31, 6'h00),         6'd32, 32'h0,        32'h0,  32'h0,  32'h8000_0000, 6'h00, 1'b0},
    {mk(2'd0, 5'd8, 6'h11),          6'd8,  32'h0,        32'h0,  32'h0,  32'h0,        6'h00, 1'b0},
    {mk(2'd1, 5'd9, 6'h03),          6'd8,  32'h0,        32'h0,  32'h0,  32'h0,        6'h00, 1'b0},
    {mk(2'd2, 5'd4, 6'h00),          6'd4,  32'h0,        32'h0,  32'h0,  32'h0,        6'h00, 1'b0},
    {mk(2'd0, 5'd3, 6'h00),          6'd4,  32'h8,        32'h0,  32'h0,  32'h0,        6'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [31:0] p, input logic [31:0] r,
                         input logic [31:0] h, input logic [31:0] w, input logic [5:0] v,
                         input logic e);
    chk({req, " post"}, 64'(post_stb), 64'(p));
    chk({req, " rst"},  64'(rst_stb),  64'(r));
    chk({req, " halt"}, 64'(halt_stb), 64'(h));
    chk({req, " wake"}, 64'(wake_stb), 64'(w));
    chk({req, " vec"},  64'(post_vec), 64'(v));
    chk({req, " err"},  64'(err_flag), 64'(e));
  endtask

  task automatic send(input logic [63:0] d, input logic [5:0] n);
    num_cpus = n; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_data = NOISE;
  endtask

  task automatic clr_err();
    err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 ready in reset", 64'(wr_ready), 64'd0);
    chk_all("R1 reset", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 ready after reset", 64'(wr_ready), 64'd1);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [204:0] e;
      e = TBL[i];
      send(e[204:141], e[140:135]);
      chk_all($sformatf("R2-table%0d R3 R4 R5 R6 R7 R8", i),
              e[134:103], e[102:71], e[70:39], e[38:7], e[6:1], e[0]);
      @(negedge clk);
      chk_all($sformatf("R10 table%0d pulse ends", i), 0, 0, 0, 0, 0, e[0]);
      clr_err();
    end

    // R11: valid low, live data
    wr_data = mk(2'd0, 5'd1, 6'h09); num_cpus = 6'd8;
    @(negedge clk); @(negedge clk);
    chk_all("R11 idle", 0, 0, 0, 0, 0, 0);

    // R10: back-to-back beats
    num_cpus = 6'd8;
    wr_data = mk(2'd2, 5'd1, 6'h00); wr_valid = 1'b1;
    @(negedge clk);
    wr_data = mk(2'd3, 5'd2, 6'h00);
    chk_all("R10 first beat", 0, 0, 32'h2, 0, 0, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    chk_all("R10 second beat", 0, 0, 0, 32'h4, 0, 0);
    @(negedge clk);
    chk_all("R10 quiet", 0, 0, 0, 0, 0, 0);

    // R9: sticky hold, then set beats clear
    send(mk(2'd1, 5'd0, 6'h00), 6'd8);
    repeat (5) @(negedge clk);
    chk("R9 sticky held", 64'(err_flag), 64'd1);
    wr_data = mk(2'd1, 5'd1, 6'h3F); wr_valid = 1'b1; err_clear = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; err_clear = 1'b0;
    chk("R9 set wins", 64'(err_flag), 64'd1);
    clr_err();
    chk("R9 cleared", 64'(err_flag), 64'd0);

    // R8: boundary at max count
    send(mk(2'd0, 5'd31, 6'h05), 6'd31);
    chk_all("R8 target equals count", 0, 0, 0, 0, 0, 0);
    send(mk(2'd0, 5'd30, 6'h05), 6'd31);
    chk_all("R8 target below count", 32'h4000_0000, 0, 0, 0, 6'h05, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule